// File: doc/BRIEF.md
# Four-Mode Universal Shift Register

A small synchronous register whose update on every rising clock edge is selected by a two-bit mode code. It can hold its contents, move the word one place toward the least significant end, move it one place toward the most significant end, or take a whole new word from the parallel data input. Each shift direction has its own serial input, which fills the bit position left empty by the shift.

Every bit's next value comes from its own four-way selector, which chooses between the bit's present value, its two neighbours and the external data bit. An active-low asynchronous clear empties the register no matter which mode is selected. The output is the register itself, so it changes only on a clock edge or a clear.

Top module: `ushift_reg`

## Requirements
- R1: While `clr_n` is low the output `q` is all zeros, whatever the clock and mode inputs do, and it is forced to zero without waiting for a clock edge.
- R2: Mode code 2'b00 (hold) leaves every bit of `q` unchanged across a rising edge.
- R3: Mode code 2'b01 (shift toward LSB) gives q[i] <= q[i+1] for i below WIDTH-1, and q[WIDTH-1] <= `ser_msb_in`.
- R4: Mode code 2'b10 (shift toward MSB) gives q[i] <= q[i-1] for i above 0, and q[0] <= `ser_lsb_in`.
- R5: Mode code 2'b11 (load) copies all of `par_in` into `q` on one rising edge.
- R6: `q` changes only on a rising clock edge or on the clear. Changing `mode`, `par_in` or a serial input between edges has no effect on `q`.
- R7: WIDTH shifts in one direction replace the whole word with the serial bits in arrival order. The first bit to arrive ends up at the far end.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Asynchronous clear, active low |
| mode | input | 2 | Operation select: 00 hold, 01 shift to LSB, 10 shift to MSB, 11 load |
| ser_msb_in | input | 1 | Serial bit entering at the MSB in mode 01 |
| ser_lsb_in | input | 1 | Serial bit entering at the LSB in mode 10 |
| par_in | input | WIDTH | Parallel word loaded in mode 11 |
| q | output | WIDTH | Register contents |

## Verification
The bench builds the register at its default width of 4. At that width the space is small enough to cover completely: every one of the 16 start values is combined with all four modes and all four serial-input pairs, and each result is compared against a next value the bench works out with shifts and masks. Long runs of shifts in one direction replace the whole word. The bench also applies a clear in the middle of a run, and it changes the inputs between edges to show they have no effect until the next edge.

// File: rtl/ushift_pkg.sv
package ushift_pkg;
    typedef enum logic [1:0] {
        OP_HOLD    = 2'b00,
        OP_TO_LSB  = 2'b01,
        OP_TO_MSB  = 2'b10,
        OP_LOAD    = 2'b11
    } op_e;
endpackage

// File: rtl/ushift_cell.sv
module ushift_cell
    import ushift_pkg::*;
(
    input  op_e  op,
    input  logic self_q,
    input  logic upper_q,
    input  logic lower_q,
    input  logic ext_d,
    output logic nxt_d
);
    always_comb begin
        unique case (op)
            OP_HOLD:   nxt_d = self_q;
            OP_TO_LSB: nxt_d = upper_q;
            OP_TO_MSB: nxt_d = lower_q;
            OP_LOAD:   nxt_d = ext_d;
            default:   nxt_d = self_q;
        endcase
    end
endmodule

// File: rtl/ushift_reg.sv
module ushift_reg
    import ushift_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic [1:0]       mode,
    input  logic             ser_msb_in,
    input  logic             ser_lsb_in,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] q
);
    localparam int TOP = WIDTH - 1;

    typedef struct packed {
        logic [WIDTH-1:0] word;
    } state_t;

    state_t st_q, st_d;
    logic [WIDTH-1:0] cell_d;
    op_e op;

    assign op = op_e'(mode);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic up_src, lo_src;
        if (i == TOP) begin : g_top
            assign up_src = ser_msb_in;
        end else begin : g_mid_up
            assign up_src = st_q.word[i+1];
        end
        if (i == 0) begin : g_bot
            assign lo_src = ser_lsb_in;
        end else begin : g_mid_lo
            assign lo_src = st_q.word[i-1];
        end
        ushift_cell i_cell (
            .op      (op),
            .self_q  (st_q.word[i]),
            .upper_q (up_src),
            .lower_q (lo_src),
            .ext_d   (par_in[i]),
            .nxt_d   (cell_d[i])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.word = cell_d;
    end

    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q = st_q.word;

    // R1: the register stays empty while the clear is held
    a_r1_clear_zero: assert property (@(posedge clk) !clr_n |-> q == '0);
    // R2: hold mode keeps the word
    a_r2_hold: assert property (@(posedge clk) disable iff (!clr_n)
        mode == 2'b00 |=> $stable(q));
    // R3: shift toward LSB
    a_r3_to_lsb: assert property (@(posedge clk) disable iff (!clr_n)
        mode == 2'b01 |=> q == {$past(ser_msb_in), $past(q[TOP:1])});
    // R4: shift toward MSB
    a_r4_to_msb: assert property (@(posedge clk) disable iff (!clr_n)
        mode == 2'b10 |=> q == {$past(q[TOP-1:0]), $past(ser_lsb_in)});
    // R5: load takes the parallel word
    a_r5_load: assert property (@(posedge clk) disable iff (!clr_n)
        mode == 2'b11 |=> q == $past(par_in));
endmodule

// File: tb/test_ushift_reg.sv
module test_ushift_reg;
    localparam int W = 4;
    localparam time TCLK = 10ns;

    logic clk = 0, clr_n = 0, smsb = 0, slsb = 0;
    logic [1:0] mode = 0;
    logic [W-1:0] par = 0, q;
    int errs = 0, checks = 0;

    ushift_reg #(.WIDTH(W)) i_ushift_reg (
        .clk(clk), .clr_n(clr_n), .mode(mode), .ser_msb_in(smsb),
        .ser_lsb_in(slsb), .par_in(par), .q(q));

    always #(TCLK/2) clk = ~clk;

    task automatic chk(input string req, input logic [W-1:0] exp);
        checks++;
        if (q !== exp) begin
            errs++;
            $display("FAIL %s: q=%b expected %b", req, q, exp);
        end
    endtask

    task automatic step;
        @(posedge clk); #(TCLK/4);
    endtask

    function automatic logic [W-1:0] model(input logic [W-1:0] cur, input logic [1:0] m,
                                           input logic sm, input logic sl, input logic [W-1:0] p);
        case (m)
            2'b00: return cur;
            2'b01: return (cur >> 1) | (W'(sm) << (W-1));
            2'b10: return ((cur << 1) & W'((1 << W) - 1)) | W'(sl);
            default: return p;
        endcase
    endfunction

    initial begin
        #(TCLK*20000);
        errs++; checks++;
        $display("FAIL watchdog: q=%b expected finish", q);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [W-1:0] exp;
        mode = 2'b11; par = '1;
        step(); step();
        chk("R1", '0);
        #(TCLK/4); clr_n = 1;
        step(); chk("R5", '1);
        // exhaustive sweep: start value x mode x serial pair
        for (int s = 0; s < (1 << W); s++)
            for (int m = 0; m < 4; m++)
                for (int sp = 0; sp < 4; sp++) begin
                    mode = 2'b11; par = W'(s); step();
                    mode = 2'(m); smsb = sp[1]; slsb = sp[0]; par = ~W'(s);
                    exp = model(W'(s), 2'(m), sp[1], sp[0], ~W'(s));
                    step();
                    case (m)
                        0: chk("R2", exp);
                        1: chk("R3", exp);
                        2: chk("R4", exp);
                        default: chk("R5", exp);
                    endcase
                end
        // R7: full-width shift toward LSB, serial bits 1,0,1,1 -> q = 1101
        mode = 2'b11; par = 4'b0000; step();
        mode = 2'b01;
        for (int k = 0; k < W; k++) begin smsb = (k != 1); step(); end
        chk("R7", 4'b1101);
        // R7: full-width shift toward MSB, serial bits 1,1,0,0 -> q = 1100
        mode = 2'b11; par = 4'b1111; step();
        mode = 2'b10;
        for (int k = 0; k < W; k++) begin slsb = (k < 2); step(); end
        chk("R7", 4'b1100);
        // R6: input changes between edges leave q alone
        mode = 2'b00; step();
        mode = 2'b11; par = 4'b0110; #1;
        chk("R6", 4'b1100);
        mode = 2'b01; smsb = 1; #1;
        chk("R6", 4'b1100);
        step(); chk("R3", 4'b1110);
        // R1: clear mid-run, asynchronous
        mode = 2'b11; par = 4'b1010; #1; clr_n = 0; #1;
        chk("R1", '0);
        step(); chk("R1", '0);
        clr_n = 1; step(); chk("R5", 4'b1010);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule